// File: doc/BRIEF.md
# Test Signature and Scratch Readback Window

This block is a small memory-mapped target that test software uses to measure access cost and to check its own load/store paths. One 8-byte slot answers every read with a fixed 32-bit signature, so a probe can be timed without side effects. A 64-byte scratch buffer can be written and read back at any byte offset with accesses of 1, 2, 4 or 8 bytes. The buffer can be reached through two separate 64-byte address ranges that share the same storage.

Requests arrive on a valid/ready port with a byte address, a size code and up to 8 bytes of write data. The target is always ready. A read returns its data one cycle after it is accepted. A write returns nothing and either updates the scratch buffer or is discarded. Window offsets (default): signature slot at 0x00-0x07, first scratch alias at 0x40-0x7F, second alias at 0x80-0xBF. The rest of the window is unmapped.

Top module: `tmw_window`

## Requirements
- R1: After reset `rsp_valid` is low and every scratch byte reads as zero.
- R2: `req_ready` is always high. An accepted read raises `rsp_valid` for exactly the next cycle. An accepted write never raises `rsp_valid`.
- R3: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. Read data is little-endian, with byte k of the access in `rsp_rdata[8k+7:8k]`. A read at signature offset 0 returns the low 8, 16 or 32 bits of the signature. An 8-byte read returns the signature in both 32-bit halves.
- R4: A read at signature offset o (1 to 7) returns, in byte k, byte (o+k) of an 8-byte pattern made of the signature twice. Byte (o+k) mod 4 of the signature is that byte, with byte 0 the least significant. Any lane where o+k is 8 or more reads 0xFF.
- R5: A write of any size to any signature offset is accepted and has no effect. Later signature reads and all scratch bytes are unchanged.
- R6: A write that lies fully inside a scratch alias stores its bytes little-endian at buffer index (address mod 64) + k. A read of any size returns the stored bytes in the same order. Unaligned offsets are allowed.
- R7: Both scratch aliases address the same 64 bytes. A byte written through one alias is read back through the other.
- R8: An access that starts inside a scratch alias but runs past its last byte is unmapped. A read returns 0xFF in every lane of the access size. A write is dropped.
- R9: An access to any other address in the window is unmapped. A read returns 0xFF in each lane of the access size. A write has no effect.
- R10: Response lanes at or above the access size read as zero.
- R11: A write accepted in the cycle a read response is presented does not alter that response. A read accepted in the cycle after a write returns the newly written bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_wdata | input | 64 | Write data, little-endian lanes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data, little-endian lanes |

## Verification
Two events can fall in the same cycle: a read response being presented and the next request, a write to the same scratch bytes, being accepted. The bench issues a read and then a write to the same address on the next cycle. It checks that the presented response still carries the old bytes. A read on the following cycle must return the new bytes. Sweeps of every address and size also exercise alias overlap, boundary crossings and signature views. Each result is compared with a byte-level model that follows the requirements.

// File: rtl/tmw_pkg.sv
package tmw_pkg;

  localparam int LANES = 8;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;

  // number of bytes moved by a size code
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // 64-bit mask covering the lanes of an access
  function automatic logic [63:0] lane_mask(input logic [1:0] code);
    logic [63:0] m;
    case (code)
      2'd0:    m = 64'h0000_0000_0000_00FF;
      2'd1:    m = 64'h0000_0000_0000_FFFF;
      2'd2:    m = 64'h0000_0000_FFFF_FFFF;
      default: m = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/tmw_decode.sv
module tmw_decode #(
  parameter int ADDR_W    = 8,
  parameter int NOP_BASE  = 'h00,
  parameter int RB_A_BASE = 'h40,
  parameter int RB_B_BASE = 'h80,
  parameter int RB_BYTES  = 64,
  localparam int IDX_W    = $clog2(RB_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit_nop,
  output logic              hit_a,
  output logic              hit_b,
  output logic [2:0]        nop_ofs,
  output logic [IDX_W-1:0]  rb_idx
);
  import tmw_pkg::*;

  localparam int NOP_BYTES = 8;
  localparam logic [ADDR_W:0] NOP_LO = (ADDR_W+1)'(NOP_BASE);
  localparam logic [ADDR_W:0] NOP_HI = (ADDR_W+1)'(NOP_BASE + NOP_BYTES);
  localparam logic [ADDR_W:0] A_LO   = (ADDR_W+1)'(RB_A_BASE);
  localparam logic [ADDR_W:0] A_HI   = (ADDR_W+1)'(RB_A_BASE + RB_BYTES);
  localparam logic [ADDR_W:0] B_LO   = (ADDR_W+1)'(RB_B_BASE);
  localparam logic [ADDR_W:0] B_HI   = (ADDR_W+1)'(RB_B_BASE + RB_BYTES);

  logic [ADDR_W:0] start_w;
  logic [ADDR_W:0] end_w;

  always_comb begin
    start_w = {1'b0, addr};
    end_w   = start_w + (ADDR_W+1)'(size_bytes(size));
    // signature slot: start inside decides, tail lanes pad with 0xFF
    hit_nop = (start_w >= NOP_LO) && (start_w < NOP_HI);
    // scratch: whole access must fit in the alias
    hit_a   = (start_w >= A_LO) && (end_w <= A_HI);
    hit_b   = (start_w >= B_LO) && (end_w <= B_HI);
    nop_ofs = addr[2:0];
    rb_idx  = addr[IDX_W-1:0];
  end

endmodule

// File: rtl/tmw_nop_view.sv
module tmw_nop_view #(
  parameter logic [31:0] SIG = 32'h5A3C_96E1
) (
  input  logic [2:0]  ofs,
  input  logic [1:0]  size,
  output logic [63:0] rdata
);
  import tmw_pkg::*;

  logic [3:0] nbytes;
  assign nbytes = size_bytes(size);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [3:0] pos;
    assign pos = {1'b0, ofs} + 4'(k);
    always_comb begin
      if (4'(k) >= nbytes)
        rdata[8*k +: 8] = 8'h00;
      else if (pos[3])
        rdata[8*k +: 8] = 8'hFF;
      else
        rdata[8*k +: 8] = SIG[8*pos[1:0] +: 8];
    end
  end

endmodule

// File: rtl/tmw_scratch.sv
module tmw_scratch #(
  parameter int  RB_BYTES = 64,
  localparam int IDX_W    = $clog2(RB_BYTES),
  localparam int MEM_W    = RB_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        size,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata
);
  import tmw_pkg::*;

  logic [MEM_W-1:0] mem_q;
  logic [MEM_W-1:0] mem_d;
  logic [3:0]       nbytes;

  assign nbytes = size_bytes(size);

  // next-state: overlay the written lanes
  always_comb begin
    mem_d = mem_q;
    for (int k = 0; k < LANES; k++) begin
      logic [IDX_W-1:0] p;
      p = idx + IDX_W'(k);
      if (4'(k) < nbytes)
        mem_d[8*p +: 8] = wdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mem_q <= '0;
    else if (wr_en)
      mem_q <= mem_d;
  end

  // read lanes, zero above the access size
  always_comb begin
    rdata = '0;
    for (int k = 0; k < LANES; k++) begin
      logic [IDX_W-1:0] p;
      p = idx + IDX_W'(k);
      if (4'(k) < nbytes)
        rdata[8*k +: 8] = mem_q[8*p +: 8];
    end
  end

  // R9, R5, R8: without a scratch write the buffer keeps its contents
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q));

endmodule

// File: rtl/tmw_window.sv
module tmw_window #(
  parameter int          ADDR_W    = 8,
  parameter int          NOP_BASE  = 'h00,
  parameter int          RB_A_BASE = 'h40,
  parameter int          RB_B_BASE = 'h80,
  parameter int          RB_BYTES  = 64,
  parameter logic [31:0] SIG       = 32'h5A3C_96E1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata
);
  import tmw_pkg::*;

  localparam int IDX_W = $clog2(RB_BYTES);

  logic             accept;
  logic             hit_nop, hit_a, hit_b, hit_rb;
  logic [2:0]       nop_ofs;
  logic [IDX_W-1:0] rb_idx;
  logic [63:0]      nop_rd, rb_rd, sel_rd;
  logic             rb_we;
  logic             rsp_valid_d, rsp_valid_q;
  logic [63:0]      rsp_data_d, rsp_data_q;
  logic             rsp_load;

  assign req_ready = 1'b1;
  assign accept    = req_valid & req_ready;

  tmw_decode #(
    .ADDR_W(ADDR_W), .NOP_BASE(NOP_BASE), .RB_A_BASE(RB_A_BASE),
    .RB_B_BASE(RB_B_BASE), .RB_BYTES(RB_BYTES)
  ) u_decode (
    .addr(req_addr), .size(req_size), .hit_nop(hit_nop), .hit_a(hit_a),
    .hit_b(hit_b), .nop_ofs(nop_ofs), .rb_idx(rb_idx)
  );

  tmw_nop_view #(.SIG(SIG)) u_nop (
    .ofs(nop_ofs), .size(req_size), .rdata(nop_rd)
  );

  assign hit_rb = hit_a | hit_b;
  assign rb_we  = accept & req_write & hit_rb;

  tmw_scratch #(.RB_BYTES(RB_BYTES)) u_scratch (
    .clk(clk), .rst_n(rst_n), .wr_en(rb_we), .idx(rb_idx),
    .size(req_size), .wdata(req_wdata), .rdata(rb_rd)
  );

  // next-state for the response stage
  always_comb begin
    if (hit_nop)     sel_rd = nop_rd;
    else if (hit_rb) sel_rd = rb_rd;
    else             sel_rd = lane_mask(req_size);
    rsp_load    = accept & ~req_write;
    rsp_valid_d = rsp_load;
    rsp_data_d  = sel_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= rsp_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rsp_data_q <= '0;
    else if (rsp_load) rsp_data_q <= rsp_data_d;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;

  // R2: accepted read answers on the next cycle
  a_r2_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R2: accepted write or idle produces no response
  a_r2_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_write) |=> !rsp_valid);

  // R7, R8: decoder never claims two regions at once
  a_r7_single_region: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_nop, hit_a, hit_b}));

  // R10: lanes above the access size are zero
  a_r10_upper_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & ~lane_mask($past(req_size))) == 64'd0));

endmodule

// File: tb/tmw_window_bench.sv
module tmw_window_bench;

  localparam logic [31:0] SIG = 32'h5A3C_96E1;
  localparam int ABASE = 'h40;
  localparam int BBASE = 'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [63:0] req_wdata = 64'd0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] model [64];

  always #4 clk = ~clk;

  tmw_window #(.SIG(SIG)) u_tmw_window (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic bit fits(int base, int a, int n);
    return (a >= base) && (a + n <= base + 64);
  endfunction

  function automatic logic [63:0] expect_rd(int a, int sz);
    logic [63:0] v = '0;
    int n = 1 << sz;
    for (int k = 0; k < n; k++) begin
      if (a < 8) begin
        if (a + k < 8) v[8*k +: 8] = SIG[8*((a + k) % 4) +: 8];
        else           v[8*k +: 8] = 8'hFF;
      end else if (fits(ABASE, a, n) || fits(BBASE, a, n))
        v[8*k +: 8] = model[(a % 64) + k];
      else
        v[8*k +: 8] = 8'hFF;
    end
    return v;
  endfunction

  function automatic string tag_of(int a, int sz);
    int n = 1 << sz;
    if (a < 8) return (a == 0) ? "R3" : "R4";
    if (fits(ABASE, a, n) || fits(BBASE, a, n)) return "R6/R7";
    if ((a >= ABASE && a < ABASE + 64) || (a >= BBASE && a < BBASE + 64)) return "R8";
    return "R9";
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_read(int a, int sz, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'(a); req_size = 2'(sz);
    check({tag, " ready"}, {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
    check($sformatf("%s addr=%0h size=%0d", tag, a, sz), rsp_rdata, expect_rd(a, sz));
  endtask

  task automatic do_write(int a, int sz, logic [63:0] d);
    int n = 1 << sz;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'(a); req_size = 2'(sz);
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 write no rsp", {63'd0, rsp_valid}, 64'd0);
    if (fits(ABASE, a, n) || fits(BBASE, a, n))
      for (int k = 0; k < n; k++) model[(a % 64) + k] = d[8*k +: 8];
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    for (int w = 0; w < 8; w++) do_read(ABASE + 8*w, 3, "R1 zero");

    // fill: lower half through alias A, upper half through alias B (R7)
    for (int i = 0; i < 64; i++)
      do_write((i < 32 ? ABASE : BBASE) + i, 0, 64'(i * 37 + 5));
    for (int w = 0; w < 8; w++) begin
      do_read(ABASE + 8*w, 3, "R7 via A");
      do_read(BBASE + 8*w, 3, "R7 via B");
    end

    // read sweep over every address and size (R3 R4 R6 R8 R9 R10)
    for (int a = 0; a < 256; a++)
      for (int sz = 0; sz < 4; sz++)
        do_read(a, sz, tag_of(a, sz));

    // write sweep: every address and size, then inspect through the other alias
    for (int a = 0; a < 256; a++)
      for (int sz = 0; sz < 4; sz++) begin
        int other;
        logic [63:0] d = {8'(a), 8'(sz), 8'(a ^ 8'h5A), 8'(a + 3),
                          8'(a * 7), 8'(sz * 11 + 1), 8'(~a), 8'(a + sz)};
        do_write(a, sz, d);
        other = (a >= BBASE && a < BBASE + 64) ? ABASE : BBASE;
        do_read(other + ((a % 64) & ~7), 3, {tag_of(a, sz), " after write"});
        do_read(other + (((a % 64) & ~7) + 8) % 64, 3, {tag_of(a, sz), " after write+8"});
        if (a < 8) do_read(0, 3, "R5 sig intact");
      end

    // R11: write accepted while read response is presented
    begin
      logic [63:0] old_v;
      do_write(ABASE + 20, 2, 64'h0000_0000_1111_2222);
      old_v = expect_rd(ABASE + 20, 2);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 8'(ABASE + 20); req_size = 2'd2;
      @(negedge clk);
      req_write = 1'b1; req_addr = 8'(BBASE + 20); req_wdata = 64'h0000_0000_ABCD_EF01;
      check("R11 rsp_valid", {63'd0, rsp_valid}, 64'd1);
      check("R11 old data kept", rsp_rdata, old_v);
      for (int k = 0; k < 4; k++) model[20 + k] = req_wdata[8*k +: 8];
      @(negedge clk);
      req_write = 1'b0; req_addr = 8'(ABASE + 20);
      check("R11 no rsp for write", {63'd0, rsp_valid}, 64'd0);
      @(negedge clk);
      req_valid = 1'b0;
      check("R11 new data", rsp_rdata, 64'h0000_0000_ABCD_EF01);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule